// File: doc/BRIEF.md
# Register-Started Block Mover Between DSP Memory and Main Memory

This block copies a run of 16-bit words between the local memories of a DSP (instruction or data) and a 32-bit addressed main memory. Software sets the direction and the target local memory in a control word. It gives the local start address and the main-memory start address, the latter written as two 16-bit halves. It then writes a byte count. That final write is the go command. No separate start bit exists.

The engine runs two cycles per word. In the first it sends a read request to the source memory. In the second it writes the returned word to the destination memory. Both memory ports are plain request/write-enable ports. They are always ready, and read data comes back one cycle after the request. Progress shows in a busy flag and in a control readback bit. The end of a transfer gives a one-cycle done pulse. The address registers advance as words move, so after a transfer they read back as the address just past the block.

Top module: `dsp_block_dma`

## Requirements
- R1: Register map on `reg_addr`:
  - 0xFFC9 is control. Bit 0 is direction, bit 1 selects instruction memory, and bit 2 reads back busy and is read-only.
  - 0xFFCB is the byte length.
  - 0xFFCD is the 16-bit DSP address.
  - 0xFFCE holds main-address bits 31..16.
  - 0xFFCF holds main-address bits 15..0.
  - `reg_rdata` shows the selected register in the same cycle, and any other address reads 0.
- R2: A write to 0xFFCB while idle starts a transfer. `busy` is 1 from the cycle after that write's clock edge.
- R3: Word count and cycle order:
  - The number of words moved is the byte length divided by two, rounded up.
  - Each word takes a read-request cycle on the source port, then a write-request cycle on the destination port whose data equals the source read data.
  - The two ports are never requested in the same cycle.
- R4: Control bit 0 equal to 0 copies main memory to DSP memory. Control bit 0 equal to 1 copies DSP memory to main memory.
- R5: On every DSP-port request, `dmem_imem` equals control bit 1 (1 = instruction memory, 0 = data memory).
- R6: Address stepping:
  - After each word, the DSP address rises by 1 and the 32-bit main address rises by 2, carrying from the low half into the high half.
  - Readback shows the advanced values.
- R7: A length of 0 makes no memory request, leaves `busy` at 0, and pulses `done` in the cycle after the write.
- R8: While busy, writes to any register (address halves, DSP address, control, length) have no effect. This includes a write in the final cycle of a transfer.
- R9: `done` is 1 for the single cycle after the last write request, and `busy` is 0 in that cycle.
- R10: After reset, every register reads 0, `busy` and `done` are 0, and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address, used for writes and readback |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Readback of the addressed register |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| dmem_req | output | 1 | DSP memory request |
| dmem_we | output | 1 | DSP memory write enable |
| dmem_imem | output | 1 | 1 = instruction memory, 0 = data memory |
| dmem_addr | output | 16 | DSP memory word address |
| dmem_wdata | output | 16 | DSP memory write data |
| dmem_rdata | input | 16 | DSP memory read data, one cycle after a read request |
| mmem_req | output | 1 | Main memory request |
| mmem_we | output | 1 | Main memory write enable |
| mmem_addr | output | 32 | Main memory byte address |
| mmem_wdata | output | 16 | Main memory write data |
| mmem_rdata | input | 16 | Main memory read data, one cycle after a read request |

## Verification
The register file and the stepping logic both want to update the DSP address in the last cycle of a transfer. In that cycle a software write to the address arrives together with the final address increment. The bench aims a DSP-address write at exactly the final write-request cycle of a one-word transfer. It then checks that readback gives the stepped value and not the written one. The same timing is used against a mid-transfer length write, which must neither restart nor lengthen the running block. A cycle-level reference model compares both memory ports on every clock.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam logic [15:0] OFS_CTRL = 16'hFFC9;
    localparam logic [15:0] OFS_LEN  = 16'hFFCB;
    localparam logic [15:0] OFS_DSPA = 16'hFFCD;
    localparam logic [15:0] OFS_MMHI = 16'hFFCE;
    localparam logic [15:0] OFS_MMLO = 16'hFFCF;

    localparam int CTL_DIR  = 0;
    localparam int CTL_IMEM = 1;
    localparam int CTL_BUSY = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_pkg::*;
#(
    parameter int DW     = 16,
    parameter int DSP_AW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [15:0]         addr,
    input  logic [DW-1:0]       wdata,
    input  logic                busy,
    input  logic                step,
    output logic [DW-1:0]       rdata,
    output logic                dir,
    output logic                imem,
    output logic                start,
    output logic [DW-1:0]       start_words,
    output logic [DSP_AW-1:0]   dsp_ptr,
    output logic [2*DW-1:0]     mm_ptr
);
    localparam int MM_AW = 2 * DW;

    typedef struct packed {
        logic              dir;
        logic              imem;
        logic [DW-1:0]     len;
        logic [DSP_AW-1:0] dsp;
        logic [MM_AW-1:0]  mm;
    } regs_t;

    regs_t r_q, r_d;
    logic  accept;
    logic [DW:0] words_wide;

    assign accept = wr_en && !busy;

    always_comb begin
        r_d = r_q;
        if (step) begin
            r_d.dsp = r_q.dsp + DSP_AW'(1);
            r_d.mm  = r_q.mm + MM_AW'(2);
        end else if (accept) begin
            case (addr)
                OFS_CTRL: begin
                    r_d.dir  = wdata[CTL_DIR];
                    r_d.imem = wdata[CTL_IMEM];
                end
                OFS_LEN:  r_d.len = wdata;
                OFS_DSPA: r_d.dsp = wdata[DSP_AW-1:0];
                OFS_MMHI: r_d.mm[MM_AW-1:DW] = wdata;
                OFS_MMLO: r_d.mm[DW-1:0] = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        words_wide  = ({1'b0, wdata} + (DW+1)'(1)) >> 1;
        start       = accept && (addr == OFS_LEN);
        start_words = words_wide[DW-1:0];
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: begin
                rdata[CTL_DIR]  = r_q.dir;
                rdata[CTL_IMEM] = r_q.imem;
                rdata[CTL_BUSY] = busy;
            end
            OFS_LEN:  rdata = r_q.len;
            OFS_DSPA: rdata = DW'(r_q.dsp);
            OFS_MMHI: rdata = r_q.mm[MM_AW-1:DW];
            OFS_MMLO: rdata = r_q.mm[DW-1:0];
            default:  rdata = '0;
        endcase
    end

    assign dir     = r_q.dir;
    assign imem    = r_q.imem;
    assign dsp_ptr = r_q.dsp;
    assign mm_ptr  = r_q.mm;
endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
    import dma_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] start_words,
    output logic          busy,
    output logic          rd_phase,
    output logic          wr_phase,
    output logic          step,
    output logic          done
);
    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          done;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (start_words == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st  = ST_READ;
                        s_d.cnt = start_words;
                    end
                end
            end
            ST_READ: s_d.st = ST_WRITE;
            ST_WRITE: begin
                s_d.cnt = s_q.cnt - CW'(1);
                if (s_q.cnt == CW'(1)) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.st = ST_READ;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, cnt: '0, done: 1'b0};
        else        s_q <= s_d;
    end

    assign busy     = (s_q.st != ST_IDLE);
    assign rd_phase = (s_q.st == ST_READ);
    assign wr_phase = (s_q.st == ST_WRITE);
    assign step     = wr_phase;
    assign done     = s_q.done;
endmodule

// File: rtl/dma_port_mux.sv
module dma_port_mux #(
    parameter int DW     = 16,
    parameter int DSP_AW = 16
) (
    input  logic              dir,
    input  logic              imem,
    input  logic              rd_phase,
    input  logic              wr_phase,
    input  logic [DSP_AW-1:0] dsp_ptr,
    input  logic [2*DW-1:0]   mm_ptr,
    input  logic [DW-1:0]     dmem_rdata,
    input  logic [DW-1:0]     mmem_rdata,
    output logic              dmem_req,
    output logic              dmem_we,
    output logic              dmem_imem,
    output logic [DSP_AW-1:0] dmem_addr,
    output logic [DW-1:0]     dmem_wdata,
    output logic              mmem_req,
    output logic              mmem_we,
    output logic [2*DW-1:0]   mmem_addr,
    output logic [DW-1:0]     mmem_wdata
);
    // dir = 0: main memory is the source; dir = 1: DSP memory is the source
    always_comb begin
        dmem_req   = dir ? rd_phase : wr_phase;
        dmem_we    = !dir && wr_phase;
        mmem_req   = dir ? wr_phase : rd_phase;
        mmem_we    = dir && wr_phase;
        dmem_imem  = imem;
        dmem_addr  = dsp_ptr;
        mmem_addr  = mm_ptr;
        dmem_wdata = mmem_rdata;
        mmem_wdata = dmem_rdata;
    end
endmodule

// File: rtl/dsp_block_dma.sv
module dsp_block_dma
    import dma_pkg::*;
#(
    parameter int DW     = 16,
    parameter int DSP_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [15:0]       reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              busy,
    output logic              done,
    output logic              dmem_req,
    output logic              dmem_we,
    output logic              dmem_imem,
    output logic [DSP_AW-1:0] dmem_addr,
    output logic [DW-1:0]     dmem_wdata,
    input  logic [DW-1:0]     dmem_rdata,
    output logic              mmem_req,
    output logic              mmem_we,
    output logic [2*DW-1:0]   mmem_addr,
    output logic [DW-1:0]     mmem_wdata,
    input  logic [DW-1:0]     mmem_rdata
);
    localparam int MM_AW = 2 * DW;

    logic              dir, imem, start, step, rd_phase, wr_phase;
    logic [DW-1:0]     start_words;
    logic [DSP_AW-1:0] dsp_ptr;
    logic [MM_AW-1:0]  mm_ptr;

    dma_regfile #(.DW(DW), .DSP_AW(DSP_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .busy(busy), .step(step), .rdata(reg_rdata),
        .dir(dir), .imem(imem), .start(start), .start_words(start_words),
        .dsp_ptr(dsp_ptr), .mm_ptr(mm_ptr)
    );

    dma_sequencer #(.CW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_words(start_words),
        .busy(busy), .rd_phase(rd_phase), .wr_phase(wr_phase),
        .step(step), .done(done)
    );

    dma_port_mux #(.DW(DW), .DSP_AW(DSP_AW)) u_mux (
        .dir(dir), .imem(imem), .rd_phase(rd_phase), .wr_phase(wr_phase),
        .dsp_ptr(dsp_ptr), .mm_ptr(mm_ptr), .dmem_rdata(dmem_rdata),
        .mmem_rdata(mmem_rdata), .dmem_req(dmem_req), .dmem_we(dmem_we),
        .dmem_imem(dmem_imem), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .mmem_req(mmem_req), .mmem_we(mmem_we), .mmem_addr(mmem_addr),
        .mmem_wdata(mmem_wdata)
    );
endmodule

// File: rtl/dma_checker.sv
module dma_checker
    import dma_pkg::*;
#(
    parameter int DW     = 16,
    parameter int DSP_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [15:0]       reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic              busy,
    input logic              done,
    input logic              dmem_req,
    input logic              mmem_req,
    input logic              step,
    input logic [DSP_AW-1:0] dsp_ptr,
    input logic [2*DW-1:0]   mm_ptr
);
    // R3: never both ports in one cycle
    a_r3_single_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_req && mmem_req));

    // R7: no requests while idle
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!dmem_req && !mmem_req));

    // R2: nonzero length write while idle starts
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !busy && reg_addr == OFS_LEN && reg_wdata != '0) |=> busy);

    // R7: zero length completes at once
    a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !busy && reg_addr == OFS_LEN && reg_wdata == '0) |=> (done && !busy));

    // R6: address stepping per word
    a_r6_dsp_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> dsp_ptr == $past(dsp_ptr) + DSP_AW'(1));
    a_r6_mm_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> mm_ptr == $past(mm_ptr) + (2*DW)'(2));

    // R8: no software change while busy
    a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step) |=> (dsp_ptr == $past(dsp_ptr) && mm_ptr == $past(mm_ptr)));

    // R9: done implies idle, end of busy gives done
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r9_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind dsp_block_dma dma_checker #(.DW(DW), .DSP_AW(DSP_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .done(done), .dmem_req(dmem_req),
    .mmem_req(mmem_req), .step(step), .dsp_ptr(dsp_ptr), .mm_ptr(mm_ptr)
);

// File: tb/sim_dsp_block_dma.sv
module sim_dsp_block_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_addr = 16'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        busy, done;
    logic        dmem_req, dmem_we, dmem_imem;
    logic [15:0] dmem_addr, dmem_wdata;
    logic [15:0] dmem_rdata = 16'h0;
    logic        mmem_req, mmem_we;
    logic [31:0] mmem_addr;
    logic [15:0] mmem_wdata;
    logic [15:0] mmem_rdata = 16'h0;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dsp_block_dma u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
        .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_imem(dmem_imem),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .mmem_req(mmem_req), .mmem_we(mmem_we), .mmem_addr(mmem_addr),
        .mmem_wdata(mmem_wdata), .mmem_rdata(mmem_rdata)
    );

    // bench memories
    logic [15:0] mm_mem [512];
    logic [15:0] dm_mem [256];
    logic [15:0] im_mem [256];

    always @(posedge clk) begin
        if (dmem_req) begin
            if (dmem_we) begin
                if (dmem_imem) im_mem[dmem_addr[7:0]] <= dmem_wdata;
                else           dm_mem[dmem_addr[7:0]] <= dmem_wdata;
            end else begin
                dmem_rdata <= dmem_imem ? im_mem[dmem_addr[7:0]] : dm_mem[dmem_addr[7:0]];
            end
        end
        if (mmem_req) begin
            if (mmem_we) mm_mem[mmem_addr[9:1]] <= mmem_wdata;
            else         mmem_rdata <= mm_mem[mmem_addr[9:1]];
        end
    end

    // reference model
    typedef struct {
        bit          on_dsp;
        bit          we;
        logic [31:0] addr;
        logic [15:0] data;
    } ev_t;

    ev_t         evq[$];
    bit          m_dir = 0, m_imem = 0, done_flag = 0;
    logic [15:0] m_len = 0, m_dsp = 0;
    logic [31:0] m_mm = 0;
    int          m_cycles = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            automatic bit mbusy = (m_cycles > 0);
            if (reg_wr_en && !mbusy) begin
                case (reg_addr)
                    16'hFFC9: begin m_dir = reg_wdata[0]; m_imem = reg_wdata[1]; end
                    16'hFFCD: m_dsp = reg_wdata;
                    16'hFFCE: m_mm[31:16] = reg_wdata;
                    16'hFFCF: m_mm[15:0] = reg_wdata;
                    16'hFFCB: begin
                        automatic int words = (int'(reg_wdata) + 1) / 2;
                        m_len = reg_wdata;
                        if (words == 0) done_flag = 1;
                        for (int i = 0; i < words; i++) begin
                            automatic logic [15:0] da = m_dsp + 16'(i);
                            automatic logic [31:0] ma = m_mm + 32'(2 * i);
                            automatic logic [15:0] v;
                            if (!m_dir) begin
                                v = mm_mem[ma[9:1]];
                                evq.push_back('{0, 0, ma, 16'h0});
                                evq.push_back('{1, 1, {16'h0, da}, v});
                            end else begin
                                v = m_imem ? im_mem[da[7:0]] : dm_mem[da[7:0]];
                                evq.push_back('{1, 0, {16'h0, da}, 16'h0});
                                evq.push_back('{0, 1, ma, v});
                            end
                        end
                        m_cycles = 2 * words;
                        m_dsp = m_dsp + 16'(words);
                        m_mm = m_mm + 32'(2 * words);
                    end
                    default: ;
                endcase
            end else if (mbusy) begin
                m_cycles--;
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            automatic bit exp_done = done_flag;
            done_flag = 0;
            check(done == exp_done, "R9 done", 32'(done), 32'(exp_done));
            check(busy == (evq.size() > 0), "R2 busy", 32'(busy), 32'(evq.size() > 0));
            if (evq.size() > 0) begin
                automatic ev_t e = evq.pop_front();
                if (e.on_dsp) begin
                    check(dmem_req && !mmem_req && dmem_we == e.we, "R4 dsp port request",
                          {dmem_req, mmem_req, dmem_we}, {1'b1, 1'b0, e.we});
                    check(dmem_addr == e.addr[15:0], "R6 dsp address", 32'(dmem_addr), e.addr);
                    check(dmem_imem == m_imem, "R5 memory select", 32'(dmem_imem), 32'(m_imem));
                    if (e.we) check(dmem_wdata == e.data, "R3 dsp write data", 32'(dmem_wdata), 32'(e.data));
                end else begin
                    check(mmem_req && !dmem_req && mmem_we == e.we, "R4 main port request",
                          {mmem_req, dmem_req, mmem_we}, {1'b1, 1'b0, e.we});
                    check(mmem_addr == e.addr, "R6 main address", mmem_addr, e.addr);
                    if (e.we) check(mmem_wdata == e.data, "R3 main write data", 32'(mmem_wdata), 32'(e.data));
                end
                if (evq.size() == 0) done_flag = 1;
            end else begin
                check(!dmem_req && !mmem_req, "R7 idle no request",
                      {dmem_req, mmem_req}, 32'h0);
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            tests++; fails++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", wd, 100000);
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) mm_mem[i] = 16'hA000 ^ 16'(i * 37);
        for (int i = 0; i < 256; i++) dm_mem[i] = 16'h5100 + 16'(i);
        for (int i = 0; i < 256; i++) im_mem[i] = 16'hC300 ^ 16'(i * 11);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state and R1 unmapped read
        rd(16'hFFC9, 16'h0, "R10 ctrl reset");
        rd(16'hFFCB, 16'h0, "R10 len reset");
        rd(16'hFFCD, 16'h0, "R10 dsp reset");
        rd(16'hFFCE, 16'h0, "R10 mm hi reset");
        rd(16'hFFCF, 16'h0, "R10 mm lo reset");
        rd(16'hFFCA, 16'h0, "R1 unmapped");

        // R4 main->DSP data, R6 carry into high half, R3 odd-free length 6
        wr(16'hFFC9, 16'h0000);
        wr(16'hFFCD, 16'h0010);
        wr(16'hFFCE, 16'h0001);
        wr(16'hFFCF, 16'hFFFC);
        wr(16'hFFCB, 16'd6);
        wait_idle();
        rd(16'hFFCD, 16'h0013, "R6 dsp after");
        rd(16'hFFCE, 16'h0002, "R6 mm hi carry");
        rd(16'hFFCF, 16'h0002, "R6 mm lo after");
        rd(16'hFFCB, 16'd6, "R1 len readback");

        // R4 DSP->main from instruction memory, R3 odd length rounds up, R1 busy bit
        wr(16'hFFC9, 16'h0003);
        wr(16'hFFCD, 16'h0040);
        wr(16'hFFCE, 16'h0000);
        wr(16'hFFCF, 16'h0100);
        wr(16'hFFCB, 16'd5);
        rd(16'hFFC9, 16'h0007, "R1 ctrl busy bit");
        wait_idle();
        rd(16'hFFC9, 16'h0003, "R1 ctrl idle");
        rd(16'hFFCD, 16'h0043, "R3 odd length words");
        rd(16'hFFCF, 16'h0106, "R6 mm lo after odd");

        // R7 zero length
        wr(16'hFFCB, 16'd0);
        wait_idle();
        rd(16'hFFCD, 16'h0043, "R7 no step on zero");

        // R8 writes while busy are dropped
        wr(16'hFFC9, 16'h0001);
        wr(16'hFFCD, 16'h0080);
        wr(16'hFFCF, 16'h0200);
        wr(16'hFFCB, 16'd8);
        wr(16'hFFCD, 16'h7777);
        wr(16'hFFCF, 16'h1234);
        wr(16'hFFC9, 16'h0002);
        wr(16'hFFCB, 16'd2);
        wait_idle();
        rd(16'hFFCD, 16'h0084, "R8 dsp kept");
        rd(16'hFFCF, 16'h0208, "R8 mm lo kept");
        rd(16'hFFC9, 16'h0001, "R8 ctrl kept");
        rd(16'hFFCB, 16'd8, "R8 len kept");

        // R8 write landing on the final step cycle
        wr(16'hFFC9, 16'h0000);
        wr(16'hFFCD, 16'h0020);
        wr(16'hFFCB, 16'd2);
        wr(16'hFFCD, 16'h5555);
        wait_idle();
        rd(16'hFFCD, 16'h0021, "R8 final-cycle write dropped");

        // R2 restart right after completion is accepted
        wr(16'hFFCB, 16'd4);
        wait_idle();
        rd(16'hFFCD, 16'h0023, "R2 restart after done");

        summary();
    end
endmodule